// File: doc/BRIEF.md
# Trinary Serial Word Encoder

This block turns nine three-level digits into a serial pulse train on a single output line. Each digit arrives as a 2-bit code that already says whether the digit is zero, one or open. The first five digits are address digits only. The last four are carried the same way and may hold either address or data. A clock-enable input named `tick` sets the pace of the output. Each digit takes two pulses of eight ticks each, and each pulse starts high. Its high time tells a narrow pulse from a wide one, and the pair of pulse widths gives the digit's value.

Operation is governed by one active-low enable. While the enable is high, the block sits idle, ignores `tick` and holds its output low. When the enable is low at a tick, the block takes a snapshot of all nine digits and sends the word twice, with a low gap after each copy, so that a receiver can compare the two copies. If the enable is still low when the trailing gap ends, another pair starts at once from a fresh snapshot. If the enable was released during a pair, that pair still runs to the end of its trailing gap.

The digit inputs are static levels and the output has no ready signal, so the block applies no back-pressure and accepts none. A receiver must keep up with the pace set by `tick`.

Top module: `trinary_word_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dout` is low and the block is idle.
- R2: While idle with `tx_en_n` high, `dout` stays low on every tick.
- R3: A tick edge that sees `tx_en_n` low while the block is idle starts a pair. The first pulse of digit 0 drives `dout` high from that edge onward.
- R4: Digits go out in index order, 0 first and 8 last. Digit i is read from `digits[2i+1:2i]`.
- R5: The codes are 2'b00 for zero, sent as two narrow pulses, and 2'b01 for one, sent as two wide pulses. 2'b10 means open and is sent as a wide pulse followed by a narrow pulse. 2'b11 is sent the same way as open.
- R6: Every pulse lasts 8 ticks. A narrow pulse is high for 1 tick and then low for 7. A wide pulse is high for 7 ticks and then low for 1.
- R7: A pair is two identical words of 144 ticks each. Each word is followed by 48 ticks of low output, which is three digit periods.
- R8: All nine digits are captured at the tick edge that starts a pair. Changes to `digits` during the pair have no effect on it.
- R9: If `tx_en_n` rises during a pair, the pair completes through its trailing gap. `dout` then stays low.
- R10: If `tx_en_n` is low at the tick that ends a trailing gap, the next pair starts at that edge with no extra delay.
- R11: State changes only on edges where `tick` is high, so `dout` stays constant across any edge where `tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable that times the pulse train |
| tx_en_n | input | 1 | Transmit enable, active low |
| digits | input | 18 | Nine 2-bit digit codes; digit i at bits [2i+1:2i] |
| dout | output | 1 | Serial pulse output |

## Verification
The bench looks for the points where a design is most likely to slip by one tick. One is the start edge: a design that starts late shifts the whole train. Another is the boundary between a word and its gap: a design that miscounts either sends an extra pulse or cuts the last one short. The bench changes the digits in the middle of a pair, which catches a design that samples each digit live and then sends two different copies. It also releases the enable early, which catches a design that cuts a pair short. It holds the enable low across two pairs, which catches a design that adds a stray gap or idle tick between pairs. The bench runs with a tick on every cycle and with sparse ticks, and it checks that `dout` never moves on an edge without a tick.

// File: rtl/tse_pkg.sv
package tse_pkg;

  // 2-bit digit codes as presented on the digit inputs
  typedef enum logic [1:0] {
    DIG_ZERO     = 2'b00,
    DIG_ONE      = 2'b01,
    DIG_OPEN     = 2'b10,
    DIG_OPEN_ALT = 2'b11
  } digit_code_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_WORD = 2'b01,
    SEQ_GAP  = 2'b10
  } seq_state_e;

  // First pulse is wide unless the digit is zero; second pulse is wide only for one.
  function automatic logic pulse_is_wide(digit_code_e code, logic second);
    if (!second) return (code != DIG_ZERO);
    return (code == DIG_ONE);
  endfunction

endpackage

// File: rtl/tse_digit_bank.sv
module tse_digit_bank
  import tse_pkg::*;
#(
  parameter int NUM_DIGITS = 9,
  parameter int SEL_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [2*NUM_DIGITS-1:0] digits_in,
  input  logic [SEL_W-1:0]        sel,
  output digit_code_e             code_out
);

  logic [2*NUM_DIGITS-1:0] held_flat;

  // One holding register per digit, loaded together at the start of a pair
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    digit_code_e held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= DIG_ZERO;
      end else if (load) begin
        held_q <= digit_code_e'(digits_in[2*g +: 2]);
      end
    end

    assign held_flat[2*g +: 2] = held_q;
  end

  always_comb begin
    code_out = DIG_ZERO;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel == SEL_W'(i)) code_out = digit_code_e'(held_flat[2*i +: 2]);
    end
  end

endmodule

// File: rtl/tse_frame_seq.sv
module tse_frame_seq
  import tse_pkg::*;
#(
  parameter int NUM_DIGITS  = 9,
  parameter int PULSE_TICKS = 8,
  parameter int GAP_TICKS   = 48,
  parameter int PH_W        = 3,
  parameter int DI_W        = 4,
  parameter int GAP_W       = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            tx_en_n,
  output logic            load_snap,
  output logic            sending,
  output logic            second_pulse,
  output logic [PH_W-1:0] phase,
  output logic [DI_W-1:0] digit_idx
);

  seq_state_e       state_q;
  logic             repeat_q;
  logic [GAP_W-1:0] gap_q;

  logic pulse_end, digit_end, word_end, gap_end, start_pair;

  assign pulse_end  = (phase == PH_W'(PULSE_TICKS - 1));
  assign digit_end  = pulse_end && second_pulse;
  assign word_end   = digit_end && (digit_idx == DI_W'(NUM_DIGITS - 1));
  assign gap_end    = (gap_q == GAP_W'(GAP_TICKS - 1));
  assign start_pair = tick && !tx_en_n &&
                      ((state_q == SEQ_IDLE) ||
                       ((state_q == SEQ_GAP) && gap_end && repeat_q));
  assign load_snap  = start_pair;
  assign sending    = (state_q == SEQ_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      repeat_q     <= 1'b0;
      gap_q        <= '0;
      phase        <= '0;
      second_pulse <= 1'b0;
      digit_idx    <= '0;
    end else if (tick) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_pair) begin
            state_q      <= SEQ_WORD;
            repeat_q     <= 1'b0;
            phase        <= '0;
            second_pulse <= 1'b0;
            digit_idx    <= '0;
          end
        end
        SEQ_WORD: begin
          if (pulse_end) begin
            phase        <= '0;
            second_pulse <= ~second_pulse;
            if (word_end) begin
              state_q <= SEQ_GAP;
              gap_q   <= '0;
            end else if (digit_end) begin
              digit_idx <= digit_idx + DI_W'(1);
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        SEQ_GAP: begin
          if (gap_end) begin
            gap_q        <= '0;
            phase        <= '0;
            second_pulse <= 1'b0;
            digit_idx    <= '0;
            if (!repeat_q) begin
              repeat_q <= 1'b1;
              state_q  <= SEQ_WORD;
            end else if (start_pair) begin
              repeat_q <= 1'b0;
              state_q  <= SEQ_WORD;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tse_pulse_shaper.sv
module tse_pulse_shaper
  import tse_pkg::*;
#(
  parameter int PH_W        = 3,
  parameter int NARROW_HIGH = 1,
  parameter int WIDE_HIGH   = 7
) (
  input  logic            sending,
  input  logic            second_pulse,
  input  logic [PH_W-1:0] phase,
  input  digit_code_e     code,
  output logic            level
);

  logic wide;
  int   high_ticks;

  always_comb begin
    wide       = pulse_is_wide(code, second_pulse);
    high_ticks = wide ? WIDE_HIGH : NARROW_HIGH;
    level      = sending && (int'(phase) < high_ticks);
  end

endmodule

// File: rtl/trinary_word_encoder.sv
module trinary_word_encoder
  import tse_pkg::*;
#(
  parameter int NUM_DIGITS  = 9,
  parameter int PULSE_TICKS = 8,
  parameter int NARROW_HIGH = 1,
  parameter int WIDE_HIGH   = 7,
  parameter int GAP_DIGITS  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    tx_en_n,
  input  logic [2*NUM_DIGITS-1:0] digits,
  output logic                    dout
);

  localparam int GAP_TICKS = GAP_DIGITS * 2 * PULSE_TICKS;
  localparam int PH_W      = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam int DI_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int GAP_W     = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  logic            load_snap;
  logic            sending;
  logic            second_pulse;
  logic [PH_W-1:0] phase;
  logic [DI_W-1:0] digit_idx;
  digit_code_e     cur_code;

  tse_frame_seq #(
    .NUM_DIGITS (NUM_DIGITS),
    .PULSE_TICKS(PULSE_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .PH_W       (PH_W),
    .DI_W       (DI_W),
    .GAP_W      (GAP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tx_en_n     (tx_en_n),
    .load_snap   (load_snap),
    .sending     (sending),
    .second_pulse(second_pulse),
    .phase       (phase),
    .digit_idx   (digit_idx)
  );

  tse_digit_bank #(
    .NUM_DIGITS(NUM_DIGITS),
    .SEL_W     (DI_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_snap),
    .digits_in(digits),
    .sel      (digit_idx),
    .code_out (cur_code)
  );

  tse_pulse_shaper #(
    .PH_W       (PH_W),
    .NARROW_HIGH(NARROW_HIGH),
    .WIDE_HIGH  (WIDE_HIGH)
  ) u_shape (
    .sending     (sending),
    .second_pulse(second_pulse),
    .phase       (phase),
    .code        (cur_code),
    .level       (dout)
  );

endmodule

// File: rtl/trinary_word_encoder_chk.sv
module trinary_word_encoder_chk #(
  parameter int NUM_DIGITS  = 9,
  parameter int PULSE_TICKS = 8,
  parameter int GAP_TICKS   = 48
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_en_n,
  input logic dout
);

  localparam int WORD_TICKS = NUM_DIGITS * 2 * PULSE_TICKS;
  localparam int PAIR_TICKS = 2 * (WORD_TICKS + GAP_TICKS);
  localparam int CW         = $clog2(PAIR_TICKS) + 1;

  // Independent timing model driven only from the ports
  logic          act;
  logic [CW-1:0] cnt;
  logic          in_word, pulse_head, pulse_tail, pair_last;

  always_comb begin
    in_word    = (int'(cnt) < WORD_TICKS) ||
                 ((int'(cnt) >= WORD_TICKS + GAP_TICKS) &&
                  (int'(cnt) < 2 * WORD_TICKS + GAP_TICKS));
    pulse_head = ((int'(cnt) % PULSE_TICKS) == 0);
    pulse_tail = ((int'(cnt) % PULSE_TICKS) == PULSE_TICKS - 1);
    pair_last  = (int'(cnt) == PAIR_TICKS - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (tick) begin
      if (!act) begin
        if (!tx_en_n) begin
          act <= 1'b1;
          cnt <= '0;
        end
      end else if (pair_last) begin
        act <= !tx_en_n;
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_IDLE_LOW:     assert property (@(posedge clk) disable iff (!rst_n) !act |-> !dout) else $error("idle output high"); // R9
  AST_START_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) (!act && tick && !tx_en_n) |=> dout) else $error("start pulse missing"); // R3
  AST_PULSE_HEAD:   assert property (@(posedge clk) disable iff (!rst_n) (act && in_word && pulse_head) |-> dout) else $error("pulse head low"); // R6
  AST_PULSE_TAIL:   assert property (@(posedge clk) disable iff (!rst_n) (act && in_word && pulse_tail) |-> !dout) else $error("pulse tail high"); // R6
  AST_GAP_LOW:      assert property (@(posedge clk) disable iff (!rst_n) (act && !in_word) |-> !dout) else $error("gap not low"); // R7
  AST_REPEAT_START: assert property (@(posedge clk) disable iff (!rst_n) (act && tick && pair_last && !tx_en_n) |=> dout) else $error("back-to-back pair late"); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !$past(tick) |-> $stable(dout)) else $error("output moved without tick"); // R11

endmodule

bind trinary_word_encoder trinary_word_encoder_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .PULSE_TICKS(PULSE_TICKS),
  .GAP_TICKS  (GAP_DIGITS * 2 * PULSE_TICKS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .tx_en_n(tx_en_n),
  .dout   (dout)
);

// File: tb/test_trinary_word_encoder.sv
module test_trinary_word_encoder;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ND    = 9;
  localparam int PT    = 8;
  localparam int GAPT  = 48;
  localparam int WORDT = ND * 2 * PT;
  localparam int PAIRT = 2 * (WORDT + GAPT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          tx_en_n = 1'b1;
  logic [2*ND-1:0] digits = '0;
  logic          dout;

  int tick_div = 2;
  int tdc = 0;

  bit    exp_q[$];
  string tag_q[$];
  string idle_tag = "R2";
  int    checks = 0;
  int    errors = 0;
  bit    mon_on = 0;
  bit    have_prev = 0;
  logic  prev_tick = 1'b0;
  logic  prev_dout = 1'b0;
  bit    e_bit;
  string e_tag;

  trinary_word_encoder i_trinary_word_encoder (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .tx_en_n(tx_en_n),
    .digits (digits),
    .dout   (dout)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tdc >= tick_div - 1) begin
      tdc  <= 0;
      tick <= 1'b1;
    end else begin
      tdc  <= tdc + 1;
      tick <= 1'b0;
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit wide_of(input logic [1:0] c, input int p);
    if (p == 0) return (c != 2'b00);
    return (c == 2'b01);
  endfunction

  // Driver side of the scoreboard: expected level for every tick interval of one pair
  task automatic push_pair(input logic [2*ND-1:0] d, input string wtag, input string first_tag);
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < ND; i++) begin
        for (int p = 0; p < 2; p++) begin
          int hi;
          hi = wide_of(d[2*i +: 2], p) ? 7 : 1;
          for (int t = 0; t < PT; t++) begin
            exp_q.push_back(t < hi);
            tag_q.push_back((w == 0 && i == 0 && p == 0 && t == 0) ? first_tag : wtag);
          end
        end
      end
      for (int t = 0; t < GAPT; t++) begin
        exp_q.push_back(1'b0);
        tag_q.push_back("R7");
      end
    end
  endtask

  // Monitor side: sample between edges, pop one expected item per tick
  always @(negedge clk) begin
    if (mon_on) begin
      if (have_prev && !prev_tick) check(dout, prev_dout, "R11");
      if (tick) begin
        if (exp_q.size() > 0) begin
          e_bit = exp_q.pop_front();
          e_tag = tag_q.pop_front();
          check(dout, e_bit, e_tag);
        end else begin
          check(dout, 1'b0, idle_tag);
        end
      end
      have_prev = 1;
    end
    prev_tick = tick;
    prev_dout = dout;
  end

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
    #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) wait_tick();
  endtask

  task automatic run_pairs(input logic [2*ND-1:0] d, input int npairs, input string wtag,
                           input bit swap, input logic [2*ND-1:0] alt);
    int rest;
    digits = d;
    wait_tick();
    for (int k = 0; k < npairs; k++) push_pair(d, wtag, "R3");
    tx_en_n = 1'b0;
    rest = (npairs - 1) * PAIRT + 20;
    if (swap) begin
      wait_ticks(5);
      digits = alt;   // R8: change mid-pair must not reach the output
      rest = rest - 5;
    end
    wait_ticks(rest);
    tx_en_n = 1'b1;   // R9: release in the middle of the first word
    while (exp_q.size() > 0) wait_tick();
    wait_ticks(30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(dout, 1'b0, "R1");
    mon_on = 1;
    wait_ticks(40);                       // R2: idle with enable high
    idle_tag = "R9";
    // R4: digit 0 = one, digit 8 = open, all others zero
    run_pairs(18'b10_00_00_00_00_00_00_00_01, 1, "R4", 1'b0, '0);
    // R5: every code value including 2'b11
    run_pairs(18'b11_10_01_00_10_01_11_00_01, 1, "R5", 1'b0, '0);
    // R6: tick on every cycle
    tick_div = 1;
    run_pairs(18'b01_10_11_01_00_01_10_11_10, 1, "R6", 1'b0, '0);
    // R10: enable held across two pairs, sparse ticks
    tick_div = 3;
    run_pairs(18'b00_01_10_00_01_10_11_01_00, 2, "R10", 1'b0, '0);
    // R8: inputs swapped five ticks after the start
    tick_div = 2;
    run_pairs(18'b01_01_00_10_00_01_00_10_01, 1, "R8", 1'b1, 18'b10_10_01_00_11_00_10_01_00);
    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule